// File: doc/BRIEF.md
# Bus Address Selector Decoder

The block watches a processor system bus (32-bit address, 8-bit write data, read and write strobes, and a 2-bit access-space code) and decides, on each rising clock edge, whether the current transaction belongs to the user logic behind it. A transaction matches when its address lies inside an inclusive window set by a lower and an upper bound, and when its access space equals the configured one. Every select output is registered, so the decode latency is one clock regardless of which address hit.

One of three behaviours is chosen by a static mode input. In selector mode the block produces separate read and write selects and holds one byte of storage that a selected write loads and a selected read returns. In chip-select mode a single select covers the whole window for any strobe. In DMA-request mode only the lower-bound address responds: a write there raises a request flag, an acknowledge input clears it, and a read there returns the flag. Read data is forced to zero whenever the block is not read-selected, so many decoders can be OR-ed onto one return path. After each selected access a wait request is held for a configurable 0 to 7 clocks to stretch the bus cycle.

Top module: `bus_sel_decoder`

## Requirements
- R1: While rst_ni is low and on the first cycles after it, every output (rd_sel_o, wr_sel_o, cs_o, wait_o, dma_req_o, rdata_o) is 0.
- R2: An address matches only when cfg_lo_i <= addr_i <= cfg_hi_i (unsigned, inclusive); one below the lower bound and one above the upper bound never select.
- R3: A match also requires space_i == cfg_space_i, where space code 0 = code, 1 = data, 2 = exported special function register, and 3 = none, which never matches.
- R4: In selector mode (cfg_mode_i = 0), rd_sel_o is high in the cycle after an edge that sampled a match with rd_i high, and wr_sel_o likewise for wr_i; the latency is exactly one clock for every address.
- R5: In chip-select mode (cfg_mode_i = 1), cs_o is high in the cycle after an edge that sampled a match with rd_i or wr_i high, while rd_sel_o and wr_sel_o stay 0.
- R6: In selector mode a matching write stores wdata_i at that edge, and a later matching read shows the stored byte on rdata_o in the cycle rd_sel_o is high.
- R7: rdata_o is all zeros in every cycle where rd_sel_o is low.
- R8: In DMA-request mode (cfg_mode_i = 2) only addr_i == cfg_lo_i with a matching space selects; a write there sets dma_req_o at that edge, dma_ack_i clears it (a same-cycle set wins), and a read there returns dma_req_o in bit 0 of rdata_o with the upper bits 0.
- R9: Each edge that produces a select loads a counter with cfg_wait_i; wait_o is high for exactly cfg_wait_i cycles starting in the cycle the select shows, a new select reloads it, and cfg_wait_i = 0 never raises wait_o.
- R10: With cfg_mode_i = 3 no select output ever rises and stored state is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 32 | Bus address |
| wdata_i | input | 8 | Bus write data |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| space_i | input | 2 | Access space of the transaction |
| cfg_lo_i | input | 32 | Inclusive lower bound (DMA mode: the only address) |
| cfg_hi_i | input | 32 | Inclusive upper bound |
| cfg_space_i | input | 2 | Access space this decoder answers |
| cfg_mode_i | input | 2 | 0 selector, 1 chip select, 2 DMA request, 3 off |
| cfg_wait_i | input | 3 | Wait cycles after each selected access |
| dma_ack_i | input | 1 | Clears the DMA request flag |
| rd_sel_o | output | 1 | Registered read select |
| wr_sel_o | output | 1 | Registered write select |
| cs_o | output | 1 | Registered chip select |
| rdata_o | output | 8 | Read data, zero unless read-selected |
| wait_o | output | 1 | Wait-state request |
| dma_req_o | output | 1 | DMA request flag |

## Verification
The hardest situation to reach is a selected access landing while the wait counter is still counting from an earlier one, combined with a DMA acknowledge arriving on the same edge as a request-setting write. The stimulus issues back-to-back selected accesses with the longest wait setting so the reload happens mid-count, and drives the acknowledge together with a base-address write and then alone. Boundary addresses one below, at and one above each bound are walked in every space code, with a reference model compared on each clock.

// File: rtl/sel_pkg.sv
package sel_pkg;
  typedef enum logic [1:0] {
    SP_CODE = 2'd0,
    SP_DATA = 2'd1,
    SP_SFR  = 2'd2,
    SP_NONE = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    MD_SEL = 2'd0,
    MD_CS  = 2'd1,
    MD_DMA = 2'd2,
    MD_OFF = 2'd3
  } mode_e;
endpackage

// File: rtl/sel_range_match.sv
module sel_range_match
  import sel_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic [1:0]        space_i,
  input  logic [1:0]        cfg_space_i,
  output logic              range_hit_o,
  output logic              base_hit_o
);
  logic space_ok;
  logic above_lo;
  logic below_hi;

  // space code 3 answers nothing
  assign space_ok    = (space_i == cfg_space_i) && (space_e'(space_i) != SP_NONE);
  assign above_lo    = (addr_i >= lo_i);
  assign below_hi    = (addr_i <= hi_i);
  assign range_hit_o = space_ok && above_lo && below_hi;
  assign base_hit_o  = space_ok && (addr_i == lo_i);
endmodule

// File: rtl/sel_wait_timer.sv
module sel_wait_timer #(
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] len_i,
  output logic              wait_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - WAIT_W'(1);
  end

  assign wait_o = (cnt_q != '0);

  // R9
  wait_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (wait_o == ($past(len_i) != '0)));

  // R9
  wait_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && !load_i) |=> (cnt_q == $past(cnt_q) - WAIT_W'(1)));
endmodule

// File: rtl/sel_dma_flag.sv
module sel_dma_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     req_q <= 1'b0;
    else if (set_i)  req_q <= 1'b1;
    else if (clr_i)  req_q <= 1'b0;
  end

  assign req_o = req_q;

  // R8
  dma_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !req_o);

  // R8
  dma_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> req_o);
endmodule

// File: rtl/bus_sel_decoder.sv
module bus_sel_decoder
  import sel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        space_i,
  input  logic [ADDR_W-1:0] cfg_lo_i,
  input  logic [ADDR_W-1:0] cfg_hi_i,
  input  logic [1:0]        cfg_space_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic              dma_ack_i,
  output logic              rd_sel_o,
  output logic              wr_sel_o,
  output logic              cs_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wait_o,
  output logic              dma_req_o
);
  localparam int PAD_W = DATA_W - 1;

  mode_e             mode;
  logic              range_hit;
  logic              base_hit;
  logic              rd_sel_d, wr_sel_d, cs_d;
  logic              rd_sel_q, wr_sel_q, cs_q, rd_dma_q;
  logic              store_we;
  logic              dma_set;
  logic              any_sel_d;
  logic [DATA_W-1:0] store_q;

  assign mode = mode_e'(cfg_mode_i);

  sel_range_match #(.ADDR_W(ADDR_W)) u_match (
    .addr_i      (addr_i),
    .lo_i        (cfg_lo_i),
    .hi_i        (cfg_hi_i),
    .space_i     (space_i),
    .cfg_space_i (cfg_space_i),
    .range_hit_o (range_hit),
    .base_hit_o  (base_hit)
  );

  always_comb begin
    rd_sel_d = 1'b0;
    wr_sel_d = 1'b0;
    cs_d     = 1'b0;
    unique case (mode)
      MD_SEL: begin
        rd_sel_d = range_hit && rd_i;
        wr_sel_d = range_hit && wr_i;
      end
      MD_CS:  cs_d = range_hit && (rd_i || wr_i);
      MD_DMA: begin
        rd_sel_d = base_hit && rd_i;
        wr_sel_d = base_hit && wr_i;
      end
      default: ;
    endcase
  end

  assign store_we  = (mode == MD_SEL) && range_hit && wr_i;
  assign dma_set   = (mode == MD_DMA) && base_hit && wr_i;
  assign any_sel_d = rd_sel_d || wr_sel_d || cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_sel_q <= 1'b0;
      wr_sel_q <= 1'b0;
      cs_q     <= 1'b0;
      rd_dma_q <= 1'b0;
    end else begin
      rd_sel_q <= rd_sel_d;
      wr_sel_q <= wr_sel_d;
      cs_q     <= cs_d;
      rd_dma_q <= (mode == MD_DMA);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       store_q <= '0;
    else if (store_we) store_q <= wdata_i;
  end

  sel_dma_flag u_dma (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (dma_set),
    .clr_i  (dma_ack_i),
    .req_o  (dma_req_o)
  );

  sel_wait_timer #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (any_sel_d),
    .len_i  (cfg_wait_i),
    .wait_o (wait_o)
  );

  // zero when idle so several decoders can be OR-ed
  always_comb begin
    rdata_o = '0;
    if (rd_sel_q) rdata_o = rd_dma_q ? {{PAD_W{1'b0}}, dma_req_o} : store_q;
  end

  assign rd_sel_o = rd_sel_q;
  assign wr_sel_o = wr_sel_q;
  assign cs_o     = cs_q;

  // R4
  rd_sel_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_o |-> $past(rd_i));

  // R4
  wr_sel_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel_o |-> $past(wr_i));

  // R5
  cs_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> (!rd_sel_o && !wr_sel_o));

  // R10
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_mode_i) == 2'd3) |-> !(rd_sel_o || wr_sel_o || cs_o));
endmodule

// File: tb/tb_bus_sel_decoder.sv
`timescale 1ns/1ps
module tb_bus_sel_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [1:0]  space = 2'd0;
  logic [31:0] lo = 32'h0000_1000, hi = 32'h0000_10FF;
  logic [1:0]  cfg_space = 2'd1;
  logic [1:0]  mode = 2'd0;
  logic [2:0]  wait_len = 3'd2;
  logic        ack = 1'b0;
  logic        rd_sel, wr_sel, cs, wait_s, dma_req;
  logic [7:0]  rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  bus_sel_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .rd_i(rd), .wr_i(wr), .space_i(space), .cfg_lo_i(lo), .cfg_hi_i(hi),
    .cfg_space_i(cfg_space), .cfg_mode_i(mode), .cfg_wait_i(wait_len),
    .dma_ack_i(ack), .rd_sel_o(rd_sel), .wr_sel_o(wr_sel), .cs_o(cs),
    .rdata_o(rdata), .wait_o(wait_s), .dma_req_o(dma_req)
  );

  // behavioural reference
  bit m_rd, m_wr, m_cs, m_rdd, m_req;
  byte unsigned m_data;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rd <= 0; m_wr <= 0; m_cs <= 0; m_rdd <= 0; m_req <= 0;
      m_data <= 0; m_cnt <= 0;
    end else begin
      longint unsigned a, l, h;
      bit sp_ok, in_rng, at_base, nr, nw, nc;
      a = addr; l = lo; h = hi;
      sp_ok   = (space == cfg_space) && (space != 2'd3);
      in_rng  = sp_ok && a >= l && a <= h;
      at_base = sp_ok && a == l;
      nr = 0; nw = 0; nc = 0;
      if (mode == 2'd0) begin nr = in_rng && rd; nw = in_rng && wr; end
      if (mode == 2'd1) nc = in_rng && (rd || wr);
      if (mode == 2'd2) begin nr = at_base && rd; nw = at_base && wr; end
      m_rd <= nr; m_wr <= nw; m_cs <= nc; m_rdd <= (mode == 2'd2);
      if (mode == 2'd0 && in_rng && wr) m_data <= wdata;
      if (mode == 2'd2 && at_base && wr) m_req <= 1;
      else if (ack) m_req <= 0;
      if (nr || nw || nc) m_cnt <= wait_len;
      else if (m_cnt > 0) m_cnt <= m_cnt - 1;
    end
  end

  task automatic chk1(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    int erd;
    erd = m_rd ? (m_rdd ? int'(m_req) : int'(m_data)) : 0;
    chk1(tag, "rd_sel", rd_sel, m_rd);
    chk1(tag, "wr_sel", wr_sel, m_wr);
    chk1(tag, "cs", cs, m_cs);
    chk1(tag, "rdata(R7)", rdata, erd);
    chk1(tag, "wait", wait_s, m_cnt != 0);
    chk1(tag, "dma_req", dma_req, m_req);
  endtask

  // drive one cycle, then compare after the edge
  task automatic cyc(string tag, logic [31:0] a, logic [1:0] sp, logic r, logic w,
                     logic [7:0] d, logic k);
    addr = a; space = sp; rd = r; wr = w; wdata = d; ack = k;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 32'h0, 2'd0, 0, 0, 8'h00, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2 boundaries in selector mode, wait 0
    wait_len = 3'd0;
    cyc("R2", 32'h0000_0FFF, 2'd1, 0, 1, 8'h11, 0);
    cyc("R2", 32'h0000_0FFF, 2'd1, 1, 0, 8'h00, 0);
    cyc("R2", 32'h0000_1000, 2'd1, 0, 1, 8'h22, 0);
    cyc("R2", 32'h0000_1000, 2'd1, 1, 0, 8'h00, 0);
    cyc("R2", 32'h0000_10FF, 2'd1, 0, 1, 8'h33, 0);
    cyc("R2", 32'h0000_10FF, 2'd1, 1, 0, 8'h00, 0);
    cyc("R2", 32'h0000_1100, 2'd1, 0, 1, 8'h44, 0);
    cyc("R2", 32'h0000_1100, 2'd1, 1, 0, 8'h00, 0);
    cyc("R2", 32'h0000_1080, 2'd1, 1, 0, 8'h00, 0);
    idle("R2", 1);

    // R3 every space code at both bounds
    for (int s = 0; s < 4; s++) begin
      cyc("R3", 32'h0000_1000, 2'(s), 0, 1, 8'(8'h50 + s), 0);
      cyc("R3", 32'h0000_10FF, 2'(s), 1, 0, 8'h00, 0);
    end
    cfg_space = 2'd2;
    cyc("R3", 32'h0000_1010, 2'd2, 0, 1, 8'hA5, 0);
    cyc("R3", 32'h0000_1010, 2'd1, 1, 0, 8'h00, 0);
    cyc("R3", 32'h0000_1010, 2'd2, 1, 0, 8'h00, 0);
    cfg_space = 2'd1;
    idle("R3", 1);

    // R4/R6 back-to-back traffic and read/write together
    cyc("R4", 32'h0000_1001, 2'd1, 0, 1, 8'h5A, 0);
    cyc("R6", 32'h0000_1002, 2'd1, 1, 0, 8'h00, 0);
    cyc("R4", 32'h0000_1003, 2'd1, 1, 1, 8'hC3, 0);
    cyc("R6", 32'h0000_1004, 2'd1, 1, 0, 8'h00, 0);
    cyc("R6", 32'h0000_1004, 2'd1, 1, 0, 8'h00, 0);
    idle("R4", 1);

    // R7 out-of-window read with non-zero store
    cyc("R7", 32'h0000_2000, 2'd1, 1, 0, 8'h00, 0);
    cyc("R7", 32'h0000_1000, 2'd0, 1, 0, 8'h00, 0);
    idle("R7", 1);

    // R9 longest wait, reload mid-count
    wait_len = 3'd7;
    cyc("R9", 32'h0000_1005, 2'd1, 1, 0, 8'h00, 0);
    idle("R9", 3);
    cyc("R9", 32'h0000_1006, 2'd1, 0, 1, 8'h77, 0);
    idle("R9", 9);
    wait_len = 3'd1;
    cyc("R9", 32'h0000_1005, 2'd1, 1, 0, 8'h00, 0);
    idle("R9", 3);

    // R5 chip-select mode
    mode = 2'd1; wait_len = 3'd2;
    cyc("R5", 32'h0000_1000, 2'd1, 1, 0, 8'h00, 0);
    cyc("R5", 32'h0000_10FF, 2'd1, 0, 1, 8'h99, 0);
    cyc("R5", 32'h0000_1100, 2'd1, 1, 0, 8'h00, 0);
    cyc("R5", 32'h0000_1050, 2'd1, 0, 0, 8'h00, 0);
    idle("R5", 3);
    mode = 2'd0;
    cyc("R5", 32'h0000_1050, 2'd1, 1, 0, 8'h00, 0);
    idle("R5", 3);

    // R8 DMA request mode
    mode = 2'd2; wait_len = 3'd0;
    cyc("R8", 32'h0000_1000, 2'd1, 1, 0, 8'h00, 0);
    cyc("R8", 32'h0000_1001, 2'd1, 0, 1, 8'hFF, 0);
    cyc("R8", 32'h0000_1000, 2'd1, 0, 1, 8'hFF, 0);
    cyc("R8", 32'h0000_1000, 2'd1, 1, 0, 8'h00, 0);
    cyc("R8", 32'h0000_1001, 2'd1, 1, 0, 8'h00, 0);
    cyc("R8", 32'h0000_1000, 2'd0, 0, 1, 8'h01, 1);
    cyc("R8", 32'h0000_1000, 2'd1, 1, 0, 8'h00, 0);
    cyc("R8", 32'h0000_1000, 2'd1, 0, 1, 8'h01, 1);
    cyc("R8", 32'h0000_1000, 2'd1, 1, 0, 8'h00, 0);
    idle("R8", 1);

    // R10 off mode: nothing selects, state untouched
    mode = 2'd3; wait_len = 3'd3;
    cyc("R10", 32'h0000_1000, 2'd1, 0, 1, 8'hEE, 0);
    cyc("R10", 32'h0000_1000, 2'd1, 1, 0, 8'h00, 0);
    idle("R10", 2);
    mode = 2'd0;
    cyc("R10", 32'h0000_1000, 2'd1, 1, 0, 8'h00, 0);
    mode = 2'd2;
    cyc("R10", 32'h0000_1000, 2'd1, 1, 0, 8'h00, 0);
    idle("R10", 4);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule